// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Update

This block is the arithmetic and logic stage of a small accumulator processor. Each cycle it takes an operation code, two data operands (`a_i`, usually the accumulator or an index register, and `m_i`, the memory or immediate byte), and the current status byte. It computes a result, says whether that result should be written back, and forms the next status byte.

The status byte holds, from bit 7 down to bit 0: negative N, overflow V, an unused bit, break B, decimal D, interrupt-disable I, zero Z and carry C. Every operation changes only its own fixed subset of these bits. All other bits, including B and the unused bit, are copied from `status_i`. Subtraction and compare treat carry as an inverted borrow. Bit test copies the two top operand bits straight into N and V. The D bit is stored and can be set or cleared, but the arithmetic is always binary.

The caller routes the operand: shifts, rotates, increment, decrement and pass act on `m_i`, and compare against an index register presents that register on `a_i`. The outputs are registered: the values for the inputs sampled at one rising edge of `clk_i` appear after that edge.

Top module: `alu8_core`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `wr_en_o` and `status_o` are 0. Otherwise the outputs for the inputs sampled at a rising edge appear after that edge.
- R2: The status bits are N=7, V=6, unused=5, B=4, D=3, I=2, Z=1, C=0. Bits 5 and 4, and every flag that the operation does not list, equal `status_i`. Whenever N and Z are updated from a written result, N is the result's bit 7 and Z is 1 exactly when the result is 0.
- R3: Add (code 1) writes A+M+C. C is the carry out. V is set when A and M have the same sign and the result's sign differs from it. N and Z are also updated.
- R4: Subtract (code 2) writes A+~M+C, so C=1 means no borrow. V is computed as for add, using ~M as the second operand. N and Z are also updated.
- R5: Compare (code 3) forms A-M with the carry-in forced to 1. It sets N and Z from the difference and C to the no-borrow bit, does not write, and leaves V unchanged.
- R6: Bit test (code 7) sets Z when (A AND M) is 0 and copies M bit 7 into N and M bit 6 into V. It does not write, and C is unchanged.
- R7: AND (4), OR (5), XOR (6), pass M (8), increment M (9) and decrement M (10) write their result modulo 256 and update only N and Z.
- R8: Shift left (11) shifts M left with 0 into bit 0. Logical shift right (12) shifts M right with 0 into bit 7, so N is always 0. For both, C takes the bit shifted out, the result is written and Z is updated.
- R9: Rotate left (13) and rotate right (14) form a 9-bit rotation through C: the old C enters the vacated end and the bit leaving the other end becomes the new C. The result is written and N and Z are updated.
- R10: Flag codes change only their target bit and do not write: clear C (15), set C (16), clear D (17), set D (18), clear I (19), set I (20), clear V (21).
- R11: Code 0 and the unused codes 22 to 31 do not write and pass the status through unchanged. For every operation that does not write, `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Register operand |
| m_i | input | 8 | Memory or immediate operand |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| wr_en_o | output | 1 | Result write enable |
| status_o | output | 8 | Registered next status byte |

## Verification
The bench builds the block with its default `DATA_W` of 8. At that width the sign bit and the bit-test source bits land on status bits 7 and 6, and the add overflow boundaries 0x7F+1 and 0x80-1 can be reached directly. The 8-bit operand space is small enough that random vectors often hit zero results, carry chains and all 32 operation codes, including the unused ones. Directed vectors cover the signed-overflow edges, an equal compare, rotates with carry set and clear, and flag operations on a status byte with all bits set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;
  localparam int ST_W = 8;

  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_U = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_CMP  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_BIT  = 5'd7,
    OP_PASS = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_SHL  = 5'd11,
    OP_SHR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_CLC  = 5'd15,
    OP_SEC  = 5'd16,
    OP_CLD  = 5'd17,
    OP_SED  = 5'd18,
    OP_CLI  = 5'd19,
    OP_SEI  = 5'd20,
    OP_CLV  = 5'd21
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opb;
  logic              ci;
  logic [DATA_W:0]   sum;

  // add uses M; subtract and compare use ~M (carry acts as no-borrow)
  assign opb = (op_i == OP_ADD) ? m_i : ~m_i;
  assign ci  = (op_i == OP_CMP) ? 1'b1 : cin_i;
  assign sum = {1'b0, a_i} + {1'b0, opb} + {{DATA_W{1'b0}}, ci};

  assign res_o  = sum[DATA_W-1:0];
  assign cout_o = sum[DATA_W];
  assign ovf_o  = (a_i[MSB] == opb[MSB]) && (sum[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_z_o,
  output logic              bit_n_o,
  output logic              bit_v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] and_v;
  assign and_v = a_i & m_i;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = and_v;
      OP_OR:   res_o = a_i | m_i;
      OP_XOR:  res_o = a_i ^ m_i;
      OP_INC:  res_o = m_i + {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC:  res_o = m_i - {{(DATA_W-1){1'b0}}, 1'b1};
      default: res_o = m_i;
    endcase
  end

  assign bit_z_o = (and_v == '0);
  assign bit_n_o = m_i[MSB];
  assign bit_v_o = m_i[MSB-1];
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  localparam int MSB = DATA_W - 1;

  logic              go_left;
  logic              fill_l;
  logic              fill_r;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;

  assign go_left = (op_i == OP_SHL) || (op_i == OP_ROL);
  assign fill_l  = (op_i == OP_ROL) && cin_i;
  assign fill_r  = (op_i == OP_ROR) && cin_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign shl[i] = fill_l;
    end else begin : g_lo
      assign shl[i] = m_i[i-1];
    end
    if (i == MSB) begin : g_hi
      assign shr[i] = fill_r;
    end else begin : g_hi
      assign shr[i] = m_i[i+1];
    end
  end

  assign res_o  = go_left ? shl : shr;
  assign cout_o = go_left ? m_i[MSB] : m_i[0];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [DATA_W-1:0] ar_res_i,
  input  logic              ar_c_i,
  input  logic              ar_v_i,
  input  logic [DATA_W-1:0] lg_res_i,
  input  logic              bit_z_i,
  input  logic              bit_n_i,
  input  logic              bit_v_i,
  input  logic [DATA_W-1:0] sh_res_i,
  input  logic              sh_c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [ST_W-1:0]   status_o
);
  localparam int MSB = DATA_W - 1;

  logic              upd_nz;
  logic [DATA_W-1:0] nz_src;

  always_comb begin
    status_o = status_i;
    result_o = '0;
    wr_en_o  = 1'b0;
    upd_nz   = 1'b0;
    nz_src   = ar_res_i;
    case (op_i)
      OP_ADD, OP_SUB: begin
        result_o       = ar_res_i;
        wr_en_o        = 1'b1;
        upd_nz         = 1'b1;
        status_o[SB_C] = ar_c_i;
        status_o[SB_V] = ar_v_i;
      end
      OP_CMP: begin
        upd_nz         = 1'b1;
        status_o[SB_C] = ar_c_i;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS, OP_INC, OP_DEC: begin
        result_o = lg_res_i;
        nz_src   = lg_res_i;
        wr_en_o  = 1'b1;
        upd_nz   = 1'b1;
      end
      OP_BIT: begin
        status_o[SB_Z] = bit_z_i;
        status_o[SB_N] = bit_n_i;
        status_o[SB_V] = bit_v_i;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result_o       = sh_res_i;
        nz_src         = sh_res_i;
        wr_en_o        = 1'b1;
        upd_nz         = 1'b1;
        status_o[SB_C] = sh_c_i;
      end
      OP_CLC: status_o[SB_C] = 1'b0;
      OP_SEC: status_o[SB_C] = 1'b1;
      OP_CLD: status_o[SB_D] = 1'b0;
      OP_SED: status_o[SB_D] = 1'b1;
      OP_CLI: status_o[SB_I] = 1'b0;
      OP_SEI: status_o[SB_I] = 1'b1;
      OP_CLV: status_o[SB_V] = 1'b0;
      default: ;
    endcase
    if (upd_nz) begin
      status_o[SB_N] = nz_src[MSB];
      status_o[SB_Z] = (nz_src == '0);
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic [ST_W-1:0]   status_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [ST_W-1:0]   status_o
);
  logic [DATA_W-1:0] ar_res, lg_res, sh_res, res_d;
  logic              ar_c, ar_v, sh_c, bit_z, bit_n, bit_v, wr_d;
  logic [ST_W-1:0]   st_d;

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op_i), .a_i(a_i), .m_i(m_i), .cin_i(status_i[SB_C]),
    .res_o(ar_res), .cout_o(ar_c), .ovf_o(ar_v)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_i), .a_i(a_i), .m_i(m_i),
    .res_o(lg_res), .bit_z_o(bit_z), .bit_n_o(bit_n), .bit_v_o(bit_v)
  );

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i(op_i), .m_i(m_i), .cin_i(status_i[SB_C]),
    .res_o(sh_res), .cout_o(sh_c)
  );

  alu8_flags #(.DATA_W(DATA_W)) u_flags (
    .op_i(op_i), .status_i(status_i),
    .ar_res_i(ar_res), .ar_c_i(ar_c), .ar_v_i(ar_v),
    .lg_res_i(lg_res), .bit_z_i(bit_z), .bit_n_i(bit_n), .bit_v_i(bit_v),
    .sh_res_i(sh_res), .sh_c_i(sh_c),
    .result_o(res_d), .wr_en_o(wr_d), .status_o(st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      status_o <= '0;
    end else begin
      result_o <= res_d;
      wr_en_o  <= wr_d;
      status_o <= st_d;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] m_i,
  input logic [ST_W-1:0]   status_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [ST_W-1:0]   status_o
);
  localparam int MSB = DATA_W - 1;

  logic            vld_q;
  logic [OP_W-1:0] op_q;
  logic [ST_W-1:0] st_q;
  logic [DATA_W-1:0] m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      op_q  <= '0;
      st_q  <= '0;
      m_q   <= '0;
    end else begin
      vld_q <= 1'b1;
      op_q  <= op_i;
      st_q  <= status_i;
      m_q   <= m_i;
    end
  end

  // R2
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> status_o[SB_U:SB_B] == st_q[SB_U:SB_B]);

  // R2
  nz_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (status_o[SB_Z] == (result_o == '0)) && (status_o[SB_N] == result_o[MSB]));

  // R7
  logic_cv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && (op_q >= OP_AND) && (op_q <= OP_DEC) && (op_q != OP_BIT)
      |-> status_o[SB_C] == st_q[SB_C] && status_o[SB_V] == st_q[SB_V]);

  // R5
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && op_q == OP_CMP |-> !wr_en_o && status_o[SB_V] == st_q[SB_V]);

  // R6
  bit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && op_q == OP_BIT |-> status_o[SB_N] == m_q[MSB] && status_o[SB_V] == m_q[MSB-1]
      && !wr_en_o);

  // R8
  shr_n_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && op_q == OP_SHR |-> !status_o[SB_N] && status_o[SB_C] == m_q[0]);

  // R10
  flag_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && op_q >= OP_CLC && op_q <= OP_CLV
      |-> !wr_en_o && $countones(status_o ^ st_q) <= 1);

  // R11
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && (op_q == OP_NOP || op_q > OP_CLV)
      |-> !wr_en_o && status_o == st_q && result_o == '0);

  // R11
  quiet_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> result_o == '0);
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .m_i(m_i),
  .status_i(status_i), .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0;
  logic [7:0] m_i = '0;
  logic [7:0] status_i = '0;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic [7:0] status_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .m_i(m_i),
    .status_i(status_i), .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o)
  );

  function automatic string tag_of(int op);
    if (op == 1) return "R3";
    if (op == 2) return "R4";
    if (op == 3) return "R5";
    if (op == 7) return "R6";
    if (op >= 4 && op <= 10) return "R7";
    if (op == 11 || op == 12) return "R8";
    if (op == 13 || op == 14) return "R9";
    if (op >= 15 && op <= 21) return "R10";
    return "R11";
  endfunction

  // behavioural model: returns {result, write, status}
  function automatic logic [16:0] model(int op, int a, int m, logic [7:0] st);
    int r = 0;
    int c = st[0];
    bit wr = 0;
    bit nz = 0;
    logic [7:0] s = st;
    int t;
    case (op)
      1, 2: begin
        int b = (op == 1) ? m : (255 - m);
        t = a + b + c;
        r = t % 256;
        s[0] = (t > 255);
        s[6] = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
        wr = 1; nz = 1;
      end
      3: begin
        t = a - m;
        s[0] = (t >= 0);
        s[7] = ((t + 256) % 256) >= 128;
        s[1] = (t == 0);
      end
      4: begin r = a & m; wr = 1; nz = 1; end
      5: begin r = a | m; wr = 1; nz = 1; end
      6: begin r = a ^ m; wr = 1; nz = 1; end
      7: begin s[1] = ((a & m) == 0); s[7] = (m >= 128); s[6] = ((m / 64) % 2 == 1); end
      8: begin r = m; wr = 1; nz = 1; end
      9: begin r = (m + 1) % 256; wr = 1; nz = 1; end
      10: begin r = (m + 255) % 256; wr = 1; nz = 1; end
      11: begin r = (m * 2) % 256; s[0] = (m >= 128); wr = 1; nz = 1; end
      12: begin r = m / 2; s[0] = m % 2; wr = 1; nz = 1; end
      13: begin r = (m * 2) % 256 + c; s[0] = (m >= 128); wr = 1; nz = 1; end
      14: begin r = m / 2 + 128 * c; s[0] = m % 2; wr = 1; nz = 1; end
      15: s[0] = 0;
      16: s[0] = 1;
      17: s[3] = 0;
      18: s[3] = 1;
      19: s[2] = 0;
      20: s[2] = 1;
      21: s[6] = 0;
      default: ;
    endcase
    if (nz) begin
      s[7] = (r >= 128);
      s[1] = (r == 0);
    end
    return {r[7:0], wr, s};
  endfunction

  task automatic check(string tag, logic [7:0] r, logic w, logic [7:0] s,
                       logic [7:0] er, logic ew, logic [7:0] es);
    n_vec++;
    if (r !== er || w !== ew || s !== es) begin
      n_bad++;
      $display("FAIL %s: got res=%02h wr=%0b st=%02h, want res=%02h wr=%0b st=%02h",
               tag, r, w, s, er, ew, es);
    end
  endtask

  task automatic apply(int op, int a, int m, logic [7:0] st);
    logic [16:0] e;
    op_i = op[4:0]; a_i = a[7:0]; m_i = m[7:0]; status_i = st;
    e = model(op, a, m, st);
    @(negedge clk_i);
    check(tag_of(op), result_o, wr_en_o, status_o, e[16:9], e[8], e[7:0]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    op_i = 5'd3; a_i = 8'h55; m_i = 8'h55; status_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    // R1 reset holds outputs at zero
    check("R1", result_o, wr_en_o, status_o, 8'h00, 1'b0, 8'h00);
    rst_ni = 1'b1;
    // R1 one-cycle latency on first vector
    apply(9, 0, 8'h41, 8'h00);
    // R3 signed overflow edges and carry
    apply(1, 8'h7F, 8'h01, 8'h00);
    apply(1, 8'hFF, 8'h01, 8'h00);
    apply(1, 8'h80, 8'h80, 8'h01);
    apply(1, 8'h10, 8'h20, 8'h01);
    // R4 borrow semantics
    apply(2, 8'h80, 8'h01, 8'h01);
    apply(2, 8'h00, 8'h01, 8'h01);
    apply(2, 8'h05, 8'h05, 8'h00);
    // R5 compare equal, less, greater; V kept
    apply(3, 8'h42, 8'h42, 8'h40);
    apply(3, 8'h10, 8'h20, 8'h00);
    apply(3, 8'h90, 8'h10, 8'h00);
    // R6 bit test
    apply(6'd7, 8'h0F, 8'hC0, 8'h01);
    apply(7, 8'hFF, 8'h41, 8'h00);
    // R7 logic, pass, inc/dec wrap
    apply(4, 8'hF0, 8'h0F, 8'h41);
    apply(5, 8'h80, 8'h01, 8'h00);
    apply(6, 8'hAA, 8'hAA, 8'hFF);
    apply(8, 8'h00, 8'h00, 8'h00);
    apply(9, 8'h00, 8'hFF, 8'h00);
    apply(10, 8'h00, 8'h00, 8'h00);
    // R8 shifts
    apply(11, 0, 8'h81, 8'h00);
    apply(12, 0, 8'h01, 8'h80);
    // R9 rotates with carry in
    apply(13, 0, 8'h80, 8'h01);
    apply(14, 0, 8'h01, 8'h01);
    apply(14, 0, 8'h02, 8'h00);
    // R10 flag ops on all-ones and all-zero status
    for (int op = 15; op <= 21; op++) begin
      apply(op, 8'h12, 8'h34, 8'hFF);
      apply(op, 8'h12, 8'h34, 8'h00);
    end
    // R11 no-op and unused codes
    apply(0, 8'hFF, 8'hFF, 8'hA5);
    apply(25, 8'h01, 8'h02, 8'h5A);
    apply(31, 8'h80, 8'h80, 8'hFF);
    // R2 random sweep over all codes and status patterns
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
            8'($urandom_range(0, 255)));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule